// File: doc/BRIEF.md
# Upper Memory Shadow Attribute Decoder

This block turns a small set of configuration values into access attributes for the upper memory region of a 1 MB real-mode address space, from 0xA0000 to 0xFFFFF. That region is split into 24 windows of 16 KB each. For the window selected by the current CPU address, the block reports whether a read is served by internal DRAM or goes outside the chip. It reports the same for a write. For every access that goes outside, it also reports whether that access should assert the ROM chip select instead of using the plain external bus.

The window attributes come from four 8-bit shadow registers, each holding four 2-bit fields. The span a field covers is 32 KB in some regions and 16 KB in others. Three further inputs feed the decode: a remap bit that removes the whole region from shadowing, a 2-bit ROM relocation code, and one expanded-memory flag per window. The decode is purely combinational. A change to any register therefore applies to the very next access, and the block needs no clock.

Top module: `umsd_decoder`

## Requirements
- R1: For an address below 0xA0000, `in_region`, `rd_int`, `wr_int`, `rd_rom` and `wr_rom` are all 0. For any address from 0xA0000 to 0xFFFFF, `in_region` is 1.
- R2: Every shadow field is 2 bits wide. Its bit 1 set makes reads internal (`rd_int`=1), and its bit 0 set makes writes internal (`wr_int`=1). This applies when the window is neither remapped nor expanded-memory mapped.
- R3: In `shd_ab`, field k (bits 2k+1:2k) covers the 32 KB from 0xA0000 + k*0x8000, which is both 16 KB windows of that span.
- R4: In `shd_c`, field k covers the 16 KB window at 0xC0000 + k*0x4000. In `shd_d`, field k covers the 16 KB window at 0xD0000 + k*0x4000.
- R5: In `shd_ef`, field k covers the 32 KB from 0xE0000 + k*0x8000.
- R6: With `remap_all`=1, every window in the region is external for both reads and writes. This holds whatever the shadow fields and expanded-memory flags are.
- R7: With `remap_all`=0, a window whose `ems_map` bit is set is internal for both reads and writes, whatever its shadow field says. Bit w of `ems_map` belongs to window w = (address - 0xA0000) / 0x4000.
- R8: `rd_rom` = window ROM flag AND NOT `rd_int`, and `wr_rom` = window ROM flag AND NOT `wr_int`. Both are 0 outside the region.
- R9: `rom_reloc` sets the ROM flag as follows. 0 flags 0xE0000-0xEFFFF. 1 flags nothing. 2 flags 0xC0000-0xC7FFF and 0xE8000-0xEFFFF. 3 flags 0xC0000-0xCFFFF.
- R10: The windows from 0xF0000 to 0xFFFFF always carry the ROM flag, whatever the value of `rom_reloc`.
- R11: The outputs are combinational functions of the address and the configuration inputs. Address bits 13:0 have no effect on them.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| cpu_addr | input | 20 | CPU memory address being decoded |
| shd_ab | input | 8 | Shadow fields for 0xA0000-0xBFFFF, 32 KB each |
| shd_c | input | 8 | Shadow fields for 0xC0000-0xCFFFF, 16 KB each |
| shd_d | input | 8 | Shadow fields for 0xD0000-0xDFFFF, 16 KB each |
| shd_ef | input | 8 | Shadow fields for 0xE0000-0xFFFFF, 32 KB each |
| remap_all | input | 1 | Region remapped away: all shadowing off, all windows external |
| rom_reloc | input | 2 | ROM relocation code that selects which windows are flagged as ROM |
| ems_map | input | 24 | Per-window expanded-memory-mapped flags |
| in_region | output | 1 | Address lies in 0xA0000-0xFFFFF |
| rd_int | output | 1 | Read is served by internal DRAM |
| wr_int | output | 1 | Write goes to internal DRAM |
| rd_rom | output | 1 | External read uses the ROM chip select |
| wr_rom | output | 1 | External write uses the ROM chip select |

## Verification
Three settings can claim the same window at the same moment: the remap bit, the window's expanded-memory flag, and its shadow field. The ROM flag then decides how any resulting external access is routed. The bench provokes this overlap in two steps. First it sets every shadow field to 11 and every expanded-memory flag to 1, then raises the remap bit; every window must go external, with ROM select wherever a ROM flag applies. Next it clears the remap bit while the flags stay set, and every window must then be internal with no ROM select, even inside 0xF0000-0xFFFFF.

// File: rtl/umsd_pkg.sv
package umsd_pkg;

    // Geometry of the decoded region
    localparam int ADDR_W      = 20;
    localparam int WIN_SHIFT   = 14;                       // 16 KB windows
    localparam int REGION_LO   = 32'h000A_0000;
    localparam int REGION_HI   = 32'h0010_0000;
    localparam int BASE_PAGE   = REGION_LO >> WIN_SHIFT;   // 40
    localparam int NUM_WIN     = (REGION_HI - REGION_LO) >> WIN_SHIFT; // 24
    localparam int PAGE_W      = ADDR_W - WIN_SHIFT;
    localparam int IDX_W       = $clog2(NUM_WIN);
    localparam int REG_W       = 8;
    localparam int FIELD_W     = 2;
    localparam int FIELDS      = REG_W / FIELD_W;

    // Window indices of group starts
    localparam int WIN_C       = (32'h000C_0000 - REGION_LO) >> WIN_SHIFT; // 8
    localparam int WIN_C_MID   = (32'h000C_8000 - REGION_LO) >> WIN_SHIFT; // 10
    localparam int WIN_D       = (32'h000D_0000 - REGION_LO) >> WIN_SHIFT; // 12
    localparam int WIN_EF      = (32'h000E_0000 - REGION_LO) >> WIN_SHIFT; // 16
    localparam int WIN_E_MID   = (32'h000E_8000 - REGION_LO) >> WIN_SHIFT; // 18
    localparam int WIN_F       = (32'h000F_0000 - REGION_LO) >> WIN_SHIFT; // 20

    typedef logic [FIELD_W-1:0] shd_field_t;

    typedef enum logic [1:0] {
        RELOC_E_WHOLE = 2'd0,
        RELOC_OFF     = 2'd1,
        RELOC_SPLIT   = 2'd2,
        RELOC_C_WHOLE = 2'd3
    } reloc_e;

    typedef struct packed {
        logic rd_int;
        logic wr_int;
        logic rd_rom;
        logic wr_rom;
    } win_attr_t;

    // Bit 1 of a field selects internal reads, bit 0 internal writes
    function automatic logic fld_rd(input shd_field_t f);
        return f[1];
    endfunction

    function automatic logic fld_wr(input shd_field_t f);
        return f[0];
    endfunction

endpackage

// File: rtl/umsd_field_map.sv
module umsd_field_map
    import umsd_pkg::*;
(
    input  logic [REG_W-1:0] shd_ab,
    input  logic [REG_W-1:0] shd_c,
    input  logic [REG_W-1:0] shd_d,
    input  logic [REG_W-1:0] shd_ef,
    input  logic             remap_all,
    output shd_field_t       win_fld [NUM_WIN]
);
    shd_field_t raw [NUM_WIN];

    for (genvar w = 0; w < NUM_WIN; w++) begin : g_win
        if (w < WIN_C) begin : g_ab
            // 32 KB granularity: two windows share one field
            assign raw[w] = shd_ab[FIELD_W*(w/2) +: FIELD_W];
        end else if (w < WIN_D) begin : g_c
            assign raw[w] = shd_c[FIELD_W*(w-WIN_C) +: FIELD_W];
        end else if (w < WIN_EF) begin : g_d
            assign raw[w] = shd_d[FIELD_W*(w-WIN_D) +: FIELD_W];
        end else begin : g_ef
            assign raw[w] = shd_ef[FIELD_W*((w-WIN_EF)/2) +: FIELD_W];
        end
        // remap forces every field to zero
        assign win_fld[w] = remap_all ? '0 : raw[w];
    end
endmodule

// File: rtl/umsd_rom_map.sv
module umsd_rom_map
    import umsd_pkg::*;
(
    input  logic [1:0]         rom_reloc,
    output logic [NUM_WIN-1:0] rom_flag
);
    reloc_e code;
    assign code = reloc_e'(rom_reloc);

    always_comb begin
        rom_flag = '0;
        for (int w = 0; w < NUM_WIN; w++) begin
            if (w >= WIN_F) begin
                rom_flag[w] = 1'b1;
            end else begin
                unique case (code)
                    RELOC_E_WHOLE: rom_flag[w] = (w >= WIN_EF);
                    RELOC_OFF:     rom_flag[w] = 1'b0;
                    RELOC_SPLIT:   rom_flag[w] = (w >= WIN_C && w < WIN_C_MID) ||
                                                 (w >= WIN_E_MID);
                    RELOC_C_WHOLE: rom_flag[w] = (w >= WIN_C && w < WIN_D);
                    default:       rom_flag[w] = 1'b0;
                endcase
            end
        end
    end
endmodule

// File: rtl/umsd_attr_resolve.sv
module umsd_attr_resolve
    import umsd_pkg::*;
(
    input  logic       remap_all,
    input  logic       ems_on,
    input  logic       rom_on,
    input  shd_field_t fld,
    output win_attr_t  attr
);
    always_comb begin
        if (remap_all) begin
            attr.rd_int = 1'b0;
            attr.wr_int = 1'b0;
        end else if (ems_on) begin
            attr.rd_int = 1'b1;
            attr.wr_int = 1'b1;
        end else begin
            attr.rd_int = fld_rd(fld);
            attr.wr_int = fld_wr(fld);
        end
        attr.rd_rom = rom_on & ~attr.rd_int;
        attr.wr_rom = rom_on & ~attr.wr_int;
    end
endmodule

// File: rtl/umsd_decoder.sv
module umsd_decoder
    import umsd_pkg::*;
(
    input  logic [ADDR_W-1:0]  cpu_addr,
    input  logic [REG_W-1:0]   shd_ab,
    input  logic [REG_W-1:0]   shd_c,
    input  logic [REG_W-1:0]   shd_d,
    input  logic [REG_W-1:0]   shd_ef,
    input  logic               remap_all,
    input  logic [1:0]         rom_reloc,
    input  logic [NUM_WIN-1:0] ems_map,
    output logic               in_region,
    output logic               rd_int,
    output logic               wr_int,
    output logic               rd_rom,
    output logic               wr_rom
);
    logic [PAGE_W-1:0] page;
    logic [PAGE_W-1:0] rel;
    logic [IDX_W-1:0]  idx;
    logic              hit;

    assign page = cpu_addr[ADDR_W-1:WIN_SHIFT];
    assign hit  = (page >= PAGE_W'(BASE_PAGE));
    assign rel  = page - PAGE_W'(BASE_PAGE);
    assign idx  = hit ? rel[IDX_W-1:0] : '0;

    shd_field_t         win_fld [NUM_WIN];
    logic [NUM_WIN-1:0] rom_flag;
    win_attr_t          attr;

    umsd_field_map u_fields (
        .shd_ab    (shd_ab),
        .shd_c     (shd_c),
        .shd_d     (shd_d),
        .shd_ef    (shd_ef),
        .remap_all (remap_all),
        .win_fld   (win_fld)
    );

    umsd_rom_map u_rom (
        .rom_reloc (rom_reloc),
        .rom_flag  (rom_flag)
    );

    umsd_attr_resolve u_resolve (
        .remap_all (remap_all),
        .ems_on    (ems_map[idx]),
        .rom_on    (rom_flag[idx]),
        .fld       (win_fld[idx]),
        .attr      (attr)
    );

    assign in_region = hit;
    assign rd_int    = hit & attr.rd_int;
    assign wr_int    = hit & attr.wr_int;
    assign rd_rom    = hit & attr.rd_rom;
    assign wr_rom    = hit & attr.wr_rom;

    // Port-level checks, skipped while any input is still unknown
    always_comb begin
        if (!$isunknown({cpu_addr, shd_ab, shd_c, shd_d, shd_ef,
                         remap_all, rom_reloc, ems_map})) begin
            assert_outside_quiet_R1: assert (in_region ||
                !(rd_int || wr_int || rd_rom || wr_rom));
            assert_remap_external_R6: assert (!(in_region && remap_all) ||
                (!rd_int && !wr_int));
            assert_ems_internal_R7: assert (!(in_region && !remap_all && ems_map[idx]) ||
                (rd_int && wr_int));
            assert_rom_only_external_R8: assert (!(rd_rom && rd_int) && !(wr_rom && wr_int));
            assert_f_area_rom_R10: assert (!(in_region && cpu_addr[19:16] == 4'hF) ||
                (rd_rom == !rd_int && wr_rom == !wr_int));
        end
    end
endmodule

// File: tb/umsd_decoder_tb.sv
module umsd_decoder_tb_top;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic [19:0] cpu_addr = '0;
    logic [7:0]  shd_ab = '0, shd_c = '0, shd_d = '0, shd_ef = '0;
    logic        remap_all = 1'b0;
    logic [1:0]  rom_reloc = 2'd0;
    logic [23:0] ems_map = '0;
    logic        in_region, rd_int, wr_int, rd_rom, wr_rom;

    int checks = 0;
    int fails  = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    umsd_decoder dut_i (
        .cpu_addr (cpu_addr), .shd_ab (shd_ab), .shd_c (shd_c), .shd_d (shd_d),
        .shd_ef (shd_ef), .remap_all (remap_all), .rom_reloc (rom_reloc),
        .ems_map (ems_map), .in_region (in_region), .rd_int (rd_int),
        .wr_int (wr_int), .rd_rom (rd_rom), .wr_rom (wr_rom)
    );

    // Expected {in_region, rd_int, wr_int, rd_rom, wr_rom} from the requirements
    function automatic logic [4:0] model(input int a);
        int f;
        int w;
        logic rom, ri, wi;
        if (a < 'hA0000) return 5'b0;
        w = (a - 'hA0000) / 'h4000;
        if (a < 'hC0000)      f = (shd_ab >> (2*((a - 'hA0000) / 'h8000))) & 3;
        else if (a < 'hD0000) f = (shd_c  >> (2*((a - 'hC0000) / 'h4000))) & 3;
        else if (a < 'hE0000) f = (shd_d  >> (2*((a - 'hD0000) / 'h4000))) & 3;
        else                  f = (shd_ef >> (2*((a - 'hE0000) / 'h8000))) & 3;
        if (a >= 'hF0000) rom = 1'b1;
        else case (rom_reloc)
            2'd0: rom = (a >= 'hE0000);
            2'd2: rom = (a >= 'hC0000 && a < 'hC8000) || (a >= 'hE8000);
            2'd3: rom = (a >= 'hC0000 && a < 'hD0000);
            default: rom = 1'b0;
        endcase
        if (remap_all)       begin ri = 0; wi = 0; end
        else if (ems_map[w]) begin ri = 1; wi = 1; end
        else                 begin ri = f[1]; wi = f[0]; end
        return {1'b1, ri, wi, rom & ~ri, rom & ~wi};
    endfunction

    task automatic check_at(input string tag, input int a);
        logic [4:0] exp, got;
        cpu_addr = 20'(a);
        #1;
        exp = model(a);
        got = {in_region, rd_int, wr_int, rd_rom, wr_rom};
        checks++;
        if (got !== exp) begin
            fails++;
            $display("FAIL %s addr=%05h got=%b expected=%b", tag, a, got, exp);
        end
    endtask

    // Every window at three offsets (R11: low bits irrelevant)
    task automatic sweep(input string tag);
        for (int w = 0; w < 24; w++) begin
            check_at(tag, 'hA0000 + w*'h4000);
            check_at(tag, 'hA0000 + w*'h4000 + 'h2A55);
            check_at(tag, 'hA0000 + w*'h4000 + 'h3FFF);
        end
    endtask

    task automatic set_regs(input logic [7:0] ab, c, d, ef);
        shd_ab = ab; shd_c = c; shd_d = d; shd_ef = ef;
    endtask

    task automatic t_reset_state;
        set_regs(0, 0, 0, 0); remap_all = 0; rom_reloc = 0; ems_map = '0;
        sweep("R1 idle");
    endtask

    task automatic t_below_region;
        set_regs(8'hFF, 8'hFF, 8'hFF, 8'hFF); ems_map = '1;
        check_at("R1 below", 'h00000);
        check_at("R1 below", 'h9FFFF);
        check_at("R1 below", 'h5C123);
        ems_map = '0;
    endtask

    task automatic t_field_encoding;
        set_regs(8'hE4, 8'hE4, 8'hE4, 8'hE4); sweep("R2 pattern E4");
        set_regs(8'h1B, 8'h1B, 8'h1B, 8'h1B); sweep("R2 pattern 1B");
    endtask

    task automatic t_granularity;
        for (int k = 0; k < 4; k++) begin
            set_regs(8'(3 << (2*k)), 0, 0, 0); sweep("R3 single field");
            set_regs(0, 8'(2 << (2*k)), 8'(1 << (2*k)), 0); sweep("R4 single field");
            set_regs(0, 0, 0, 8'(3 << (2*k))); sweep("R5 single field");
        end
    endtask

    task automatic t_remap_vs_ems;
        set_regs(8'hFF, 8'hFF, 8'hFF, 8'hFF); ems_map = '1; remap_all = 1;
        rom_reloc = 2'd0; sweep("R6 remap over all");
        rom_reloc = 2'd3; sweep("R6 remap rom");
        remap_all = 0; set_regs(0, 0, 0, 0); sweep("R7 ems all");
        ems_map = 24'h5A_C3_96; set_regs(8'h66, 8'h99, 8'h27, 8'hD2); sweep("R7 ems mixed");
        ems_map = '0;
    endtask

    task automatic t_rom_reloc;
        for (int r = 0; r < 4; r++) begin
            rom_reloc = 2'(r);
            set_regs(0, 0, 0, 0); sweep("R9 reloc");
            set_regs(8'h66, 8'h66, 8'h66, 8'h66); sweep("R8 split rom");
        end
    endtask

    task automatic t_f_always_rom;
        rom_reloc = 2'd1; set_regs(0, 0, 0, 8'h90); sweep("R10 F rom");
    endtask

    task automatic t_live_update;
        rom_reloc = 2'd0; set_regs(0, 0, 0, 0);
        cpu_addr = 20'hC4000;
        check_at("R11 before", 'hC4000);
        shd_c = 8'h0C;     // field 1 -> 11
        check_at("R11 after write", 'hC4000);
        remap_all = 1;
        check_at("R11 after remap", 'hC4000);
        remap_all = 0;
    endtask

    initial begin
        repeat (2) @(posedge clk);
        t_reset_state();
        t_below_region();
        t_field_encoding();
        t_granularity();
        t_remap_vs_ems();
        t_rom_reloc();
        t_f_always_rom();
        t_live_update();
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        checks++; fails++;
        $display("FAIL watchdog expired");
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end
endmodule